// File: doc/BRIEF.md
# Register-Mapped Iterative Integer Divider

This block is a 32-bit integer divider that a processor drives entirely through a small bank of word registers on a single register port. The dividend and the divisor can each be written at two addresses: one treats the operands as unsigned numbers and the other as two's-complement numbers. Whichever alias the most recent operand write used decides the signedness of the division. Every operand write starts a fresh calculation.

The calculation runs for a fixed eight clock cycles. In each cycle a radix-16 restoring step produces four quotient bits. The quotient and remainder then appear in their result registers. A read-only status word shows a ready bit and a dirty bit. The dirty bit marks results that software has not yet collected; it clears when the quotient is read. Both result registers can be written directly. This lets an interrupted context put back a pending result without starting a new division.

Top module: `mmdiv_top`

## Requirements
- R1: After reset the status word reads 1 (ready bit 0 = 1, dirty bit 1 = 0), and the quotient and the remainder both read 0.
- R2: Word address 0 holds the unsigned dividend alias, 1 the unsigned divisor alias, 2 the signed dividend alias and 3 the signed divisor alias. Addresses 0 and 2 read back the stored dividend, and addresses 1 and 3 read back the stored divisor.
- R3: After an operand write, status bit 0 reads 0 for exactly 8 consecutive cycles and then reads 1, and the results are valid from that point.
- R4: An unsigned division returns the floor quotient at address 4 and the remainder at address 5.
- R5: A signed division truncates the quotient toward zero, and the remainder takes the sign of the dividend. The most negative dividend divided by -1 gives the quotient 0x80000000 and the remainder 0.
- R6: An unsigned division by zero returns the quotient 0xFFFFFFFF and a remainder equal to the dividend.
- R7: A signed division by zero returns the quotient -1 when the dividend is non-negative and +1 when it is negative, and a remainder equal to the dividend.
- R8: An operand write while a calculation is running restarts the count of 8 cycles, and the result uses the latest operands.
- R9: A write to any of the addresses 0 to 5 sets status bit 1. Reading address 4 clears it. Reading address 5 leaves it set.
- R10: Writes to addresses 4 and 5 store the value given, read back unchanged and start no calculation.
- R11: Address 6 (status) ignores writes and its bits 31:2 read 0. Address 7 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |

## Verification
The bench targets the sign corners: a negative dividend against a positive divisor and the reverse, the most negative dividend divided by -1, and division by zero in both modes. A design that fixed up the signs wrongly would return floor-style quotients or remainders with the wrong sign, and one that treated zero specially would break the saturated ±1 rule. The bench counts the busy cycles of each calculation and restarts one calculation halfway. An off-by-one counter, or a design that kept the first operands, shows up there directly. It also follows the dirty bit through reads of the remainder and the quotient, and checks that writes to the status word and to the unused address are ignored.

// File: rtl/mmdiv_pkg.sv
package mmdiv_pkg;
  typedef enum logic [2:0] {
    A_UDVD = 3'd0,
    A_UDVS = 3'd1,
    A_SDVD = 3'd2,
    A_SDVS = 3'd3,
    A_QUOT = 3'd4,
    A_REM  = 3'd5,
    A_STAT = 3'd6,
    A_NONE = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/mmdiv_stage.sv
// One radix-2 restoring step: shift in a dividend bit, subtract if it fits.
module mmdiv_stage #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted = {rem_i, quo_i[W-1]};
    diff    = shifted - {1'b0, div_i};
    fits    = (shifted >= {1'b0, div_i});
    rem_o   = fits ? diff[W-1:0] : shifted[W-1:0];
    quo_o   = {quo_i[W-2:0], fits};
  end
endmodule

// File: rtl/mmdiv_iter.sv
// Chains BPC restoring steps into one clock cycle of work.
module mmdiv_iter #(
  parameter int W   = 32,
  parameter int BPC = 4
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W-1:0] rem_c [BPC+1];
  logic [W-1:0] quo_c [BPC+1];

  assign rem_c[0] = rem_i;
  assign quo_c[0] = quo_i;

  for (genvar g = 0; g < BPC; g++) begin : g_step
    mmdiv_stage #(.W(W)) u_stage (
      .rem_i (rem_c[g]),
      .quo_i (quo_c[g]),
      .div_i (div_i),
      .rem_o (rem_c[g+1]),
      .quo_o (quo_c[g+1])
    );
  end

  assign rem_o = rem_c[BPC];
  assign quo_o = quo_c[BPC];
endmodule

// File: rtl/mmdiv_top.sv
module mmdiv_top
  import mmdiv_pkg::*;
#(
  parameter int W   = 32,
  parameter int BPC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_we,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata
);
  localparam int STEPS = W / BPC;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(STEPS);

  // reset: asynchronous assert, synchronous release
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  // decode
  logic wr, rd, wr_dvd, wr_dvs, op_wr, res_wr, rd_quot;
  always_comb begin
    wr      = bus_sel && bus_we;
    rd      = bus_sel && !bus_we;
    wr_dvd  = wr && (bus_addr == A_UDVD || bus_addr == A_SDVD);
    wr_dvs  = wr && (bus_addr == A_UDVS || bus_addr == A_SDVS);
    op_wr   = wr_dvd || wr_dvs;
    res_wr  = wr && (bus_addr == A_QUOT || bus_addr == A_REM);
    rd_quot = rd && (bus_addr == A_QUOT);
  end

  // state
  logic [W-1:0]  dvd_q, dvd_d, dvs_q, dvs_d;
  logic [W-1:0]  quot_q, quot_d, rem_q, rem_d;
  logic          sgn_q, sgn_d, dirty_q, dirty_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  wq_q, wq_d, wr_q, wr_d, wd_q, wd_d;
  logic          nq_q, nq_d, nr_q, nr_d;
  logic          op_en, work_en, res_en;
  logic [W-1:0]  it_rem, it_quo;
  logic          busy, finish;

  mmdiv_iter #(.W(W), .BPC(BPC)) u_iter (
    .rem_i (wr_q),
    .quo_i (wq_q),
    .div_i (wd_q),
    .rem_o (it_rem),
    .quo_o (it_quo)
  );

  always_comb begin
    busy    = (cnt_q != '0);
    finish  = busy && (cnt_q == CW'(1)) && !op_wr;
    op_en   = op_wr;
    work_en = op_wr || busy;
    res_en  = res_wr || finish;

    dvd_d = wr_dvd ? bus_wdata : dvd_q;
    dvs_d = wr_dvs ? bus_wdata : dvs_q;
    sgn_d = op_wr ? (bus_addr == A_SDVD || bus_addr == A_SDVS) : sgn_q;

    dirty_d = dirty_q;
    if (rd_quot)               dirty_d = 1'b0;
    if (op_wr || res_wr)       dirty_d = 1'b1;

    // work registers: load magnitudes on start, iterate while busy
    if (op_wr) begin
      wq_d  = (sgn_d && dvd_d[W-1]) ? -dvd_d : dvd_d;
      wd_d  = (sgn_d && dvs_d[W-1]) ? -dvs_d : dvs_d;
      wr_d  = '0;
      nq_d  = sgn_d && (dvd_d[W-1] ^ dvs_d[W-1]);
      nr_d  = sgn_d && dvd_d[W-1];
      cnt_d = CNT_LOAD;
    end else begin
      wq_d  = it_quo;
      wd_d  = wd_q;
      wr_d  = it_rem;
      nq_d  = nq_q;
      nr_d  = nr_q;
      cnt_d = cnt_q - CW'(1);
    end

    // results: a direct write takes priority over a finishing calculation
    quot_d = quot_q;
    rem_d  = rem_q;
    if (finish) begin
      quot_d = nq_q ? -it_quo : it_quo;
      rem_d  = nr_q ? -it_rem : it_rem;
    end
    if (wr && bus_addr == A_QUOT) quot_d = bus_wdata;
    if (wr && bus_addr == A_REM)  rem_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      dvd_q   <= '0;
      dvs_q   <= '0;
      sgn_q   <= 1'b0;
      dirty_q <= 1'b0;
      cnt_q   <= '0;
      wq_q    <= '0;
      wr_q    <= '0;
      wd_q    <= '0;
      nq_q    <= 1'b0;
      nr_q    <= 1'b0;
      quot_q  <= '0;
      rem_q   <= '0;
    end else begin
      if (op_en) begin
        dvd_q <= dvd_d;
        dvs_q <= dvs_d;
        sgn_q <= sgn_d;
      end
      dirty_q <= dirty_d;
      if (work_en) begin
        cnt_q <= cnt_d;
        wq_q  <= wq_d;
        wr_q  <= wr_d;
        wd_q  <= wd_d;
        nq_q  <= nq_d;
        nr_q  <= nr_d;
      end
      if (res_en) begin
        quot_q <= quot_d;
        rem_q  <= rem_d;
      end
    end
  end

  // read mux
  always_comb begin
    case (bus_addr)
      A_UDVD, A_SDVD: bus_rdata = dvd_q;
      A_UDVS, A_SDVS: bus_rdata = dvs_q;
      A_QUOT:         bus_rdata = quot_q;
      A_REM:          bus_rdata = rem_q;
      A_STAT:         bus_rdata = {{(W-2){1'b0}}, dirty_q, !busy};
      default:        bus_rdata = '0;
    endcase
  end

  // assertions
  assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rs_n)
    op_wr |=> (bus_rdata[0] == 1'b0 || bus_addr != A_STAT) && busy);

  assert_countdown_R3: assert property (@(posedge clk) disable iff (!rs_n)
    (busy && !op_wr) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rs_n)
    (busy && op_wr) |=> (cnt_q == CNT_LOAD));

  assert_dirty_set_R9: assert property (@(posedge clk) disable iff (!rs_n)
    (op_wr || res_wr) |=> dirty_q);

  assert_dirty_clear_R9: assert property (@(posedge clk) disable iff (!rs_n)
    rd_quot |=> !dirty_q);

  assert_idle_results_hold_R10: assert property (@(posedge clk) disable iff (!rs_n)
    (!busy && !wr) |=> ($stable(quot_q) && $stable(rem_q)));

  assert_status_write_ignored_R11: assert property (@(posedge clk) disable iff (!rs_n)
    (wr && (bus_addr == A_STAT || bus_addr == A_NONE)) |=>
      (dirty_q == $past(dirty_q) && $stable(quot_q) && $stable(dvd_q)));
endmodule

// File: tb/tb_mmdiv_top.sv
module tb_mmdiv_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] q;
    logic [31:0] r;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  mmdiv_top dut (
    .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bread(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  // expected result from the requirements
  function automatic void model(bit sgn, logic [31:0] a, logic [31:0] b,
                                output logic [31:0] q, output logic [31:0] r);
    if (b == 0) begin
      r = a;
      if (!sgn)       q = 32'hFFFF_FFFF;
      else if (a[31]) q = 32'd1;
      else            q = 32'hFFFF_FFFF;
    end else if (!sgn) begin
      q = a / b;
      r = a % b;
    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      q = 32'h8000_0000;
      r = 32'd0;
    end else begin
      q = $signed(a) / $signed(b);
      r = $signed(a) % $signed(b);
    end
  endfunction

  // count busy status reads until ready; R3 expects 8
  task automatic wait_ready(string tag);
    logic [31:0] s;
    int n = 0;
    for (int i = 0; i < 40; i++) begin
      bread(3'd6, s);
      if (s[0]) break;
      n++;
    end
    check({"R3 busy cycles ", tag}, 32'(n), 32'd8);
  endtask

  // driver: launch a division and queue its expected outcome
  task automatic drive(bit sgn, logic [31:0] a, logic [31:0] b, string tag);
    exp_t e;
    bwrite(sgn ? 3'd2 : 3'd0, a);
    bwrite(sgn ? 3'd3 : 3'd1, b);
    model(sgn, a, b, e.q, e.r);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: pop the expectation and compare the results, tracking dirty (R9)
  task automatic monitor();
    exp_t e;
    logic [31:0] v;
    e = sb.pop_front();
    bread(3'd6, v); check({"R9 dirty set ", e.tag}, v, 32'd3);
    bread(3'd5, v); check({e.tag, " remainder"}, v, e.r);
    bread(3'd6, v); check({"R9 dirty kept after rem read ", e.tag}, v, 32'd3);
    bread(3'd4, v); check({e.tag, " quotient"}, v, e.q);
    bread(3'd6, v); check({"R9 dirty cleared ", e.tag}, v, 32'd1);
  endtask

  task automatic run(bit sgn, logic [31:0] a, logic [31:0] b, string tag);
    drive(sgn, a, b, tag);
    wait_ready(tag);
    monitor();
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    bread(3'd6, v); check("R1 status", v, 32'd1);
    bread(3'd4, v); check("R1 quotient", v, 32'd0);
    bread(3'd5, v); check("R1 remainder", v, 32'd0);

    // R4 unsigned
    run(1'b0, 32'd100, 32'd7, "R4 100/7");
    run(1'b0, 32'hFFFF_FFFF, 32'd3, "R4 max/3");
    run(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, "R4 big/max");
    run(1'b0, 32'd5, 32'd9, "R4 small/large");
    // R2 readback of operands through both aliases
    bread(3'd0, v); check("R2 dividend alias 0", v, 32'd5);
    bread(3'd2, v); check("R2 dividend alias 2", v, 32'd5);
    bread(3'd1, v); check("R2 divisor alias 1", v, 32'd9);
    bread(3'd3, v); check("R2 divisor alias 3", v, 32'd9);

    // R5 signed
    run(1'b1, -32'sd7, 32'd2, "R5 -7/2");
    run(1'b1, 32'd7, -32'sd2, "R5 7/-2");
    run(1'b1, -32'sd7, -32'sd2, "R5 -7/-2");
    run(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R5 min/-1");
    run(1'b1, 32'h8000_0000, 32'd10, "R5 min/10");
    // same bit pattern, unsigned alias (R2 mode select)
    run(1'b0, -32'sd7, 32'd2, "R2 unsigned alias of -7/2");

    // R6, R7 divide by zero
    run(1'b0, 32'd1234, 32'd0, "R6 1234/0");
    run(1'b1, 32'd55, 32'd0, "R7 55/0");
    run(1'b1, -32'sd55, 32'd0, "R7 -55/0");

    // R8 restart: new dividend mid-calculation
    bwrite(3'd0, 32'd1000);
    bwrite(3'd1, 32'd10);
    repeat (3) @(posedge clk);
    drive(1'b0, 32'd999, 32'd4, "R8 restart");
    wait_ready("R8");
    monitor();

    // R10 direct result writes
    bwrite(3'd4, 32'h1234_5678);
    bwrite(3'd5, 32'h0BAD_F00D);
    bread(3'd6, v); check("R10 ready stays, dirty set", v, 32'd3);
    bread(3'd5, v); check("R10 remainder readback", v, 32'h0BAD_F00D);
    bread(3'd4, v); check("R10 quotient readback", v, 32'h1234_5678);

    // R11 status and unused address ignore writes
    bwrite(3'd6, 32'hFFFF_FFFF);
    bread(3'd6, v); check("R11 status write ignored", v, 32'd1);
    bwrite(3'd7, 32'hFFFF_FFFF);
    bread(3'd6, v); check("R11 unused write ignored", v, 32'd1);
    bread(3'd7, v); check("R11 unused reads zero", v, 32'd0);
    bread(3'd4, v); check("R11 quotient untouched", v, 32'h1234_5678);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule